// File: doc/BRIEF.md
# Cipher Accelerator Control Front End

This block is the register and sequencing front end of a block-cipher accelerator. A byte-wide register bus reaches a control register, a status register and two byte-serial data ports. The data ports fill a state memory and a key memory. Each memory has its own write pointer and read pointer, and both pointers advance by one on every access. Both memories are offered in full to an external cipher engine. The rounds themselves are computed outside this block.

Software starts, aborts and steers an operation through the control register. The block sends the engine a one-cycle start pulse, a one-cycle abort pulse and a direction level. It holds a busy bit until the engine answers with done or error. The state port can fold each new byte into the byte already stored there instead of overwriting it. An auto-start mode launches the engine on its own once a fresh state block has been loaded completely. A self-clearing soft reset returns the whole block to its power-up contents.

Top module: `cipher_ctl_front`

## Requirements
- R1: The control register is at address 0: bit 7 GO, bit 6 AUTO, bit 5 SRST, bit 4 DIR, bit 2 XOR. Bits 3, 1 and 0 read 0. The status register is at address 1: bit 0 done, bit 7 error, and all other bits read 0. After reset both registers read 0x00, busy is 0, and all engine outputs are 0.
- R2: Writing GO=1 while idle sets GO and busy on the next clock edge, and eng_start is high for exactly that one cycle. Writing GO=1 while busy sets the error flag and produces no eng_start.
- R3: Writing GO=0 while busy clears GO and busy on the next edge, and eng_abort is high for exactly that one cycle.
- R4: While busy, eng_done sets the done flag and eng_error sets the error flag, and either one clears GO. While idle, both inputs are ignored. Writing 1 to a status bit clears that flag.
- R5: A write to address 2 stores the byte at the state write pointer, and a read of address 2 with bus_rd returns the byte at the state read pointer. Address 3 does the same for the key memory. Every access advances its own pointer, and the pointer wraps from 15 to 0. Byte i of a memory appears on eng_state or eng_key at bits [8i+7:8i].
- R6: With XOR=1, a state write stores the new byte XOR the byte already stored at that position. With XOR=0, the new byte overwrites it.
- R7: Writing SRST=1 makes SRST read 1 for exactly one cycle. On the following edge every register, pointer and memory byte returns to zero.
- R8: eng_decrypt follows DIR: 0 means encrypt and 1 means decrypt.
- R9: A fill count of state writes saturates at 16 and is cleared by every start. When AUTO=1 is set while all four pointers are 0 and the fill count is 0, auto-start is armed. While armed and idle, with all pointers at 0 and the fill count at 16, GO and eng_start rise one cycle after the 16th state byte is written.
- R10: If AUTO is set after state bytes have already been counted, completing the block does not start the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; advances the data-port read pointers |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_abort | output | 1 | One-cycle abort pulse to the engine |
| eng_decrypt | output | 1 | Direction to the engine: 1 means decrypt |
| eng_done | input | 1 | Engine completion |
| eng_error | input | 1 | Engine failure |
| eng_state | output | 128 | State memory contents, byte 0 in the low bits |
| eng_key | output | 128 | Key memory contents, byte 0 in the low bits |
| busy | output | 1 | An operation is in progress |

## Verification
A corrupted pointer shows up as soon as a data port is read back, and it also moves bytes to the wrong lane of eng_state or eng_key. A wrong fill count or a wrong arming flag shows at the ports as a missing or spurious eng_start exactly one cycle after the sixteenth state write. A stuck GO bit shows as busy never falling within the engine latency after done or error. A soft reset that clears too early or too late leaves SRST visible in the control readback for the wrong number of cycles.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
    localparam logic [1:0] OFS_CTRL  = 2'd0;
    localparam logic [1:0] OFS_STAT  = 2'd1;
    localparam logic [1:0] OFS_STATE = 2'd2;
    localparam logic [1:0] OFS_KEY   = 2'd3;

    localparam int unsigned CB_GO   = 7;
    localparam int unsigned CB_AUTO = 6;
    localparam int unsigned CB_SRST = 5;
    localparam int unsigned CB_DIR  = 4;
    localparam int unsigned CB_XOR  = 2;

    localparam int unsigned SB_DONE = 0;
    localparam int unsigned SB_ERR  = 7;
endpackage

// File: rtl/cfe_byte_bank.sv
module cfe_byte_bank #(
    parameter int unsigned DEPTH    = 16,
    parameter int unsigned DW       = 8,
    parameter bit          XOR_LOAD = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_clr,
    input  logic                wr_en,
    input  logic                xor_en,
    input  logic [DW-1:0]       wr_data,
    input  logic                rd_en,
    output logic [DW-1:0]       rd_data,
    output logic                ptrs_zero,
    output logic [DEPTH*DW-1:0] contents
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wptr;
        logic [PW-1:0]            rptr;
    } bank_t;

    bank_t q, d;
    logic [DW-1:0] merged;

    generate
        if (XOR_LOAD) begin : g_xor
            assign merged = xor_en ? (q.mem[q.wptr] ^ wr_data) : wr_data;
        end else begin : g_plain
            logic unused_xor;
            assign unused_xor = xor_en;
            assign merged     = wr_data;
        end
    endgenerate

    always_comb begin
        d = q;
        if (sw_clr) begin
            d = '0;
        end else begin
            if (wr_en) begin
                d.mem[q.wptr] = merged;
                d.wptr        = (q.wptr == LAST) ? '0 : q.wptr + PW'(1);
            end
            if (rd_en) begin
                d.rptr = (q.rptr == LAST) ? '0 : q.rptr + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data   = q.mem[q.rptr];
    assign ptrs_zero = (q.wptr == '0) && (q.rptr == '0);
    assign contents  = q.mem;
endmodule

// File: rtl/cfe_seq.sv
module cfe_seq
    import cfe_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_wdata,
    input  logic       stat_wr,
    input  logic [7:0] stat_wdata,
    input  logic       state_wr,
    input  logic       ptrs_zero,
    input  logic       eng_done,
    input  logic       eng_error,
    output logic [7:0] ctrl_rdata,
    output logic [7:0] stat_rdata,
    output logic       sw_clr,
    output logic       xor_mode,
    output logic       eng_start,
    output logic       eng_abort,
    output logic       eng_decrypt,
    output logic       busy
);
    localparam int unsigned FW = $clog2(DEPTH + 1);
    localparam logic [FW-1:0] FULL = FW'(DEPTH);

    typedef struct packed {
        logic          go;
        logic          auto_en;
        logic          srst;
        logic          dir;
        logic          xr;
        logic          done;
        logic          err;
        logic          armed;
        logic [FW-1:0] fill;
        logic          start_p;
        logic          abort_p;
    } seq_t;

    seq_t q, d;

    logic unused_bits;
    assign unused_bits = ^{ctrl_wdata[3], ctrl_wdata[1:0], stat_wdata[6:1]};

    always_comb begin
        d         = q;
        d.start_p = 1'b0;
        d.abort_p = 1'b0;
        if (q.srst) begin
            d         = '0;
            d.abort_p = q.go;
        end else begin
            if (stat_wr) begin
                if (stat_wdata[SB_DONE]) d.done = 1'b0;
                if (stat_wdata[SB_ERR])  d.err  = 1'b0;
            end
            if (state_wr && (q.fill != FULL)) d.fill = q.fill + FW'(1);
            if (ctrl_wr) begin
                d.auto_en = ctrl_wdata[CB_AUTO];
                d.srst    = ctrl_wdata[CB_SRST];
                d.dir     = ctrl_wdata[CB_DIR];
                d.xr      = ctrl_wdata[CB_XOR];
                if (ctrl_wdata[CB_GO]) begin
                    if (q.go) begin
                        d.err = 1'b1;
                    end else begin
                        d.go      = 1'b1;
                        d.start_p = 1'b1;
                        d.fill    = '0;
                    end
                end else if (q.go) begin
                    d.go      = 1'b0;
                    d.abort_p = 1'b1;
                end
            end
            // arming follows the registered AUTO bit and an empty, rewound block
            if (!d.auto_en) begin
                d.armed = 1'b0;
            end else if (q.auto_en && ptrs_zero && (q.fill == '0)) begin
                d.armed = 1'b1;
            end
            // auto-start once the block is full and every pointer is back at 0
            if (q.armed && q.auto_en && ptrs_zero && (q.fill == FULL) && !q.go && !ctrl_wr) begin
                d.go      = 1'b1;
                d.start_p = 1'b1;
                d.fill    = '0;
            end
            // engine completion ends the operation
            if (q.go && (eng_done || eng_error)) begin
                d.go = 1'b0;
                if (eng_done)  d.done = 1'b1;
                if (eng_error) d.err  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ctrl_rdata  = {q.go, q.auto_en, q.srst, q.dir, 1'b0, q.xr, 2'b00};
    assign stat_rdata  = {q.err, 6'b000000, q.done};
    assign sw_clr      = q.srst;
    assign xor_mode    = q.xr;
    assign eng_start   = q.start_p;
    assign eng_abort   = q.abort_p;
    assign eng_decrypt = q.dir;
    assign busy        = q.go;
endmodule

// File: rtl/cipher_ctl_front.sv
module cipher_ctl_front
    import cfe_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [1:0]         bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic               eng_start,
    output logic               eng_abort,
    output logic               eng_decrypt,
    input  logic               eng_done,
    input  logic               eng_error,
    output logic [DEPTH*8-1:0] eng_state,
    output logic [DEPTH*8-1:0] eng_key,
    output logic               busy
);
    logic       ctrl_wr, stat_wr, state_wr, key_wr, state_rd, key_rd;
    logic       sw_clr, xor_mode, st_zero, key_zero;
    logic [7:0] ctrl_rd, stat_rd, state_byte, key_byte;

    assign ctrl_wr  = bus_wr && (bus_addr == OFS_CTRL);
    assign stat_wr  = bus_wr && (bus_addr == OFS_STAT);
    assign state_wr = bus_wr && (bus_addr == OFS_STATE);
    assign key_wr   = bus_wr && (bus_addr == OFS_KEY);
    assign state_rd = bus_rd && (bus_addr == OFS_STATE);
    assign key_rd   = bus_rd && (bus_addr == OFS_KEY);

    cfe_seq #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(bus_wdata),
        .stat_wr(stat_wr), .stat_wdata(bus_wdata),
        .state_wr(state_wr), .ptrs_zero(st_zero && key_zero),
        .eng_done(eng_done), .eng_error(eng_error),
        .ctrl_rdata(ctrl_rd), .stat_rdata(stat_rd),
        .sw_clr(sw_clr), .xor_mode(xor_mode),
        .eng_start(eng_start), .eng_abort(eng_abort),
        .eng_decrypt(eng_decrypt), .busy(busy)
    );

    cfe_byte_bank #(.DEPTH(DEPTH), .DW(8), .XOR_LOAD(1'b1)) u_state (
        .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr),
        .wr_en(state_wr), .xor_en(xor_mode), .wr_data(bus_wdata),
        .rd_en(state_rd), .rd_data(state_byte),
        .ptrs_zero(st_zero), .contents(eng_state)
    );

    cfe_byte_bank #(.DEPTH(DEPTH), .DW(8), .XOR_LOAD(1'b0)) u_key (
        .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr),
        .wr_en(key_wr), .xor_en(1'b0), .wr_data(bus_wdata),
        .rd_en(key_rd), .rd_data(key_byte),
        .ptrs_zero(key_zero), .contents(eng_key)
    );

    always_comb begin
        case (bus_addr)
            OFS_CTRL:  bus_rdata = ctrl_rd;
            OFS_STAT:  bus_rdata = stat_rd;
            OFS_STATE: bus_rdata = state_byte;
            default:   bus_rdata = key_byte;
        endcase
    end
endmodule

// File: rtl/cfe_checker.sv
module cfe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       eng_start,
    input logic       eng_abort,
    input logic       eng_done,
    input logic       eng_error,
    input logic       busy,
    input logic       sw_clr
);
    logic ctrl_w;
    assign ctrl_w = bus_wr && (bus_addr == 2'd0);

    // R2: a start pulse always comes with the busy state
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> busy);

    // R2: a GO write while busy never restarts the engine
    a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_w && bus_wdata[7]) |=> !eng_start);

    // R3: clearing GO while busy aborts on the next cycle
    a_r3_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_w && !bus_wdata[7]) |=> (eng_abort && !busy));

    // R4: done or error from the engine ends the operation
    a_r4_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (eng_done || eng_error)) |=> !busy);

    // R7: soft reset is visible for one cycle only
    a_r7_srst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> !sw_clr);

    // R7: soft reset leaves the block idle
    a_r7_srst_idle: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> !busy);
endmodule

bind cipher_ctl_front cfe_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .eng_start(eng_start), .eng_abort(eng_abort),
    .eng_done(eng_done), .eng_error(eng_error), .busy(busy), .sw_clr(sw_clr)
);

// File: tb/test_cipher_ctl_front.sv
module test_cipher_ctl_front;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [7:0]   bus_wdata = 8'h00;
    logic [7:0]   bus_rdata;
    logic         eng_start, eng_abort, eng_decrypt, eng_done, eng_error, busy;
    logic [127:0] eng_state, eng_key;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // engine stub: fixed latency, answers done or error, stops on abort
    logic [3:0] cnt = 4'd0;
    logic       stub_err = 1'b0;
    logic       frc_done = 1'b0, frc_err = 1'b0;
    assign eng_done  = ((cnt == 4'd1) && !stub_err) || frc_done;
    assign eng_error = ((cnt == 4'd1) && stub_err) || frc_err;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (eng_start)      cnt <= 4'd4;
        else if (eng_abort) cnt <= 4'd0;
        else if (cnt != 0)  cnt <= cnt - 4'd1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 50000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    cipher_ctl_front i_cipher_ctl_front (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_abort(eng_abort), .eng_decrypt(eng_decrypt),
        .eng_done(eng_done), .eng_error(eng_error),
        .eng_state(eng_state), .eng_key(eng_key), .busy(busy)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic srst();
        wr(2'd0, 8'h20);
        @(negedge clk);
    endtask

    // {kind[1:0] 1=write 2=read, addr[1:0], wdata[7:0], expected[7:0]}
    localparam logic [19:0] VEC [14] = '{
        {2'd2, 2'd0, 8'h00, 8'h00},
        {2'd2, 2'd1, 8'h00, 8'h00},
        {2'd1, 2'd2, 8'hA5, 8'h00},
        {2'd1, 2'd2, 8'h3C, 8'h00},
        {2'd2, 2'd2, 8'h00, 8'hA5},
        {2'd2, 2'd2, 8'h00, 8'h3C},
        {2'd1, 2'd0, 8'h0F, 8'h00},
        {2'd2, 2'd0, 8'h00, 8'h04},
        {2'd1, 2'd3, 8'h11, 8'h00},
        {2'd1, 2'd3, 8'h22, 8'h00},
        {2'd2, 2'd3, 8'h00, 8'h11},
        {2'd2, 2'd3, 8'h00, 8'h22},
        {2'd1, 2'd0, 8'h00, 8'h00},
        {2'd2, 2'd0, 8'h00, 8'h00}
    };

    initial begin
        logic [7:0]   v;
        logic [127:0] exp_st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the engine side
        chk("R1 engine outputs after reset",
            {eng_start, eng_abort, eng_decrypt, busy}, 4'b0000);
        chk("R1 memories after reset", eng_state | eng_key, 128'd0);

        // table: register layout (R1), data ports (R5)
        for (int i = 0; i < 14; i++) begin
            if (VEC[i][19:18] == 2'd1) begin
                wr(VEC[i][17:16], VEC[i][15:8]);
            end else begin
                @(negedge clk);
                bus_addr = VEC[i][17:16]; bus_rd = 1'b1;
                #1;
                chk($sformatf("R1 R5 table vector %0d", i), bus_rdata, VEC[i][7:0]);
                @(negedge clk);
                bus_rd = 1'b0;
            end
        end

        // R7: soft reset self-clears, then everything returns to zero
        wr(2'd0, 8'h20);
        peek(2'd0, v); chk("R7 SRST reads 1 for one cycle", v, 8'h20);
        @(negedge clk);
        peek(2'd0, v); chk("R7 SRST cleared by hardware", v, 8'h00);
        chk("R7 memories cleared", eng_state | eng_key, 128'd0);
        wr(2'd2, 8'h77);
        @(negedge clk); bus_addr = 2'd2; bus_rd = 1'b1; #1;
        chk("R7 state pointers back at zero", bus_rdata, 8'h77);
        @(negedge clk); bus_rd = 1'b0;

        // R5 wrap and R6 XOR load
        srst();
        exp_st = '0;
        for (int i = 0; i < 16; i++) begin
            wr(2'd2, 8'(i * 17));
            exp_st[8*i +: 8] = 8'(i * 17);
        end
        chk("R5 byte lanes after full block", eng_state, exp_st);
        wr(2'd0, 8'h04);
        wr(2'd2, 8'hF0);
        wr(2'd2, 8'h0F);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h55);
        chk("R6 XOR into wrapped byte 0", eng_state[7:0], 8'hF0);
        chk("R6 XOR into byte 1", eng_state[15:8], 8'h1E);
        chk("R6 overwrite with XOR off", eng_state[23:16], 8'h55);
        chk("R5 byte 3 untouched", eng_state[31:24], 8'h33);

        // R2 and R8: manual start with decrypt direction
        wr(2'd0, 8'h90);
        chk("R2 start pulse and busy", {eng_start, busy}, 2'b11);
        chk("R8 decrypt forwarded", eng_decrypt, 1'b1);
        peek(2'd0, v); chk("R2 GO reads 1 while running", v, 8'h90);
        @(negedge clk);
        chk("R2 start pulse lasts one cycle", eng_start, 1'b0);
        wr(2'd0, 8'h90);
        peek(2'd1, v); chk("R2 start while busy flags error", v, 8'h80);
        chk("R2 no restart while busy", {eng_start, busy}, 2'b01);
        idle(6);
        chk("R4 done clears busy", busy, 1'b0);
        peek(2'd1, v); chk("R4 done flag set", v, 8'h81);
        wr(2'd1, 8'h81);
        peek(2'd1, v); chk("R4 flags clear on write one", v, 8'h00);

        // R4 engine error path, R8 encrypt direction
        stub_err = 1'b1;
        wr(2'd0, 8'h80);
        chk("R8 encrypt forwarded", eng_decrypt, 1'b0);
        idle(8);
        peek(2'd1, v); chk("R4 error flag set", v, 8'h80);
        peek(2'd0, v); chk("R4 error clears GO", v, 8'h00);
        wr(2'd1, 8'h80);
        stub_err = 1'b0;

        // R3 abort
        wr(2'd0, 8'h80);
        wr(2'd0, 8'h00);
        chk("R3 abort pulse and idle", {eng_abort, busy}, 2'b10);
        @(negedge clk);
        chk("R3 abort pulse lasts one cycle", eng_abort, 1'b0);
        idle(6);
        peek(2'd1, v); chk("R3 no completion after abort", v, 8'h00);

        // R4 engine answers ignored while idle
        @(negedge clk); frc_done = 1'b1; frc_err = 1'b1;
        @(negedge clk); frc_done = 1'b0; frc_err = 1'b0;
        peek(2'd1, v); chk("R4 idle done/error ignored", v, 8'h00);

        // R9 auto-start
        srst();
        wr(2'd0, 8'h40);
        for (int i = 0; i < 16; i++) wr(2'd3, 8'(i));
        for (int i = 0; i < 16; i++) wr(2'd2, 8'(255 - i));
        chk("R9 no start before full block settles", {eng_start, busy}, 2'b00);
        @(negedge clk);
        chk("R9 auto start fires", {eng_start, busy}, 2'b11);
        idle(8);
        chk("R9 auto run completes", busy, 1'b0);

        // R10 late AUTO stays disarmed
        srst();
        for (int i = 0; i < 3; i++) wr(2'd2, 8'(i));
        wr(2'd0, 8'h40);
        for (int i = 0; i < 16; i++) wr(2'd3, 8'(i));
        for (int i = 3; i < 16; i++) wr(2'd2, 8'(i));
        idle(4);
        chk("R10 late AUTO does not start", busy, 1'b0);
        peek(2'd0, v); chk("R10 GO stays 0", v, 8'h40);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule